// File: doc/BRIEF.md
# External Memory Wait-State Sequencer

This block sits between a processor core's memory access pipeline and its external bus. For every accepted access it works out how many extra cycles the core must be held. The number depends on the address space or spaces the access touches, on whether each touched space lives on or off chip, and on four programmable wait-state fields. The block then holds a stall line high for exactly that many cycles and marks the end of the access with a one-cycle done pulse.

The four fields, one each for the X data, Y data, program and I/O spaces, sit in a 16-bit bus timing register that has a simple write port. A dual access reads X and Y together. When only one of its two halves is off chip, it costs that half's wait states. When both halves are off chip, the two bus cycles are serialized. That costs two extra cycles on top of both spaces' counts, so the worst case is 32 cycles.

The sequencer is a three-state machine:

- **ST_IDLE** waits for a request.
- On an accepted request, ST_IDLE moves to **ST_STALL** when the computed cost is non-zero. It moves straight to **ST_DONE** when the cost is zero.
- ST_STALL loads the cost into a down-counter and stays until the counter reaches one. It then moves to ST_DONE.
- ST_DONE lasts one cycle and always returns to ST_IDLE.

Requests are sampled only in ST_IDLE.

Top module: `memstall_seq`

## Requirements
- R1: After reset, stall and done are low and every wait-state field reads as 15, so an external X access made before any register write stalls for 15 cycles.
- R2: A single-space access (type code X=0, Y=1, P=2, I/O=3) whose space flag is low (internal) adds zero cycles whatever the fields hold.
- R3: A single-space access whose space flag is high (external) adds that space's field. The X field is register bits 3:0, Y is 7:4, P is 11:8 and I/O is 15:12.
- R4: A dual access (type code 4) with X internal and Y external adds the Y field only.
- R5: A dual access with X external and Y internal adds the X field only.
- R6: A dual access with both halves external adds 2 plus the X field plus the Y field, up to 32 cycles.
- R7: A dual access with both halves internal adds zero cycles.
- R8: With a cost of N, stall is high from the cycle after acceptance for exactly N cycles. Done is then high for one cycle, and stall and done are never high together. With N = 0, done rises in the cycle after acceptance and stall stays low.
- R9: A request is ignored while stall or done is high: the running access keeps its length, and no new access starts from the done cycle.
- R10: A register write takes effect only from the next accepted request. A write made during a stall, or in the same cycle as the accepted request, leaves that access's length unchanged.
- R11: Type codes 5, 6 and 7 add zero cycles whatever the space flags and fields are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the bus timing register |
| cfg_wdata | input | 16 | Write data: X, Y, P, I/O fields from the low bits |
| req | input | 1 | Access request, sampled in the idle state |
| acc_type | input | 3 | Access type code |
| x_ext | input | 1 | X space is off chip |
| y_ext | input | 1 | Y space is off chip |
| p_ext | input | 1 | Program space is off chip |
| io_ext | input | 1 | I/O space is off chip |
| stall | output | 1 | Holds the core while wait states elapse |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench builds the block with its default 4-bit field width, which gives a 6-bit down-counter. With that width the full 0 to 15 range of every field and the 32-cycle worst case of a serialized dual access can be reached in a short run. Directed cases cover the reset fields, each field's bit position, each internal and external combination of a dual access, and register writes that land during a stall or together with a request. A seeded random mix of register values, type codes and flags then exercises the cost computation and the counter across many lengths.

// File: rtl/memstall_pkg.sv
package memstall_pkg;
    localparam int NUM_SPACES = 4;

    typedef enum logic [2:0] {
        ACC_X  = 3'd0,
        ACC_Y  = 3'd1,
        ACC_P  = 3'd2,
        ACC_IO = 3'd3,
        ACC_XY = 3'd4
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_DONE  = 2'd2
    } st_e;
endpackage

// File: rtl/memstall_cfg_reg.sv
module memstall_cfg_reg #(
    parameter int FIELD_W = 4,
    parameter int NUM_FIELDS = 4,
    localparam int REG_W = FIELD_W * NUM_FIELDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    // Reset to the slowest timing so off-chip devices work before setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/memstall_cost.sv
module memstall_cost
    import memstall_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int CNT_W = 6,
    localparam int REG_W = FIELD_W * NUM_SPACES
) (
    input  logic [REG_W-1:0] cfg,
    input  logic [2:0]       acc_type,
    input  logic             x_ext,
    input  logic             y_ext,
    input  logic             p_ext,
    input  logic             io_ext,
    output logic [CNT_W-1:0] cost
);
    logic [CNT_W-1:0] fld [NUM_SPACES];

    // Slice and zero-extend each wait-state field.
    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_fld
        assign fld[g] = {{(CNT_W-FIELD_W){1'b0}}, cfg[g*FIELD_W +: FIELD_W]};
    end

    localparam logic [CNT_W-1:0] SERIAL_EXTRA = CNT_W'(2);

    always_comb begin
        cost = '0;
        unique case (acc_type)
            ACC_X:   cost = x_ext  ? fld[0] : '0;
            ACC_Y:   cost = y_ext  ? fld[1] : '0;
            ACC_P:   cost = p_ext  ? fld[2] : '0;
            ACC_IO:  cost = io_ext ? fld[3] : '0;
            ACC_XY: begin
                unique case ({x_ext, y_ext})
                    2'b11:   cost = SERIAL_EXTRA + fld[0] + fld[1];
                    2'b10:   cost = fld[0];
                    2'b01:   cost = fld[1];
                    default: cost = '0;
                endcase
            end
            default: cost = '0;
        endcase
    end
endmodule

// File: rtl/memstall_fsm.sv
module memstall_fsm
    import memstall_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] cost,
    output logic             stall,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    st_e              state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next state and counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (cost == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_STALL;
                        cnt_d   = cost;
                    end
                end
            end
            ST_STALL: begin
                if (cnt_q == ONE) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs decoded from the state alone.
    always_comb begin
        stall = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_STALL: stall = 1'b1;
            ST_DONE:  done  = 1'b1;
            default: begin
                stall = 1'b0;
                done  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/memstall_seq.sv
module memstall_seq
    import memstall_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [FIELD_W*NUM_SPACES-1:0] cfg_wdata,
    input  logic                          req,
    input  logic [2:0]                    acc_type,
    input  logic                          x_ext,
    input  logic                          y_ext,
    input  logic                          p_ext,
    input  logic                          io_ext,
    output logic                          stall,
    output logic                          done
);
    localparam int REG_W   = FIELD_W * NUM_SPACES;
    localparam int MAX_CST = 2 * ((1 << FIELD_W) - 1) + 2;
    localparam int CNT_W   = $clog2(MAX_CST + 1);

    logic [REG_W-1:0] cfg_q;
    logic [CNT_W-1:0] cost_w;

    memstall_cfg_reg #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_SPACES)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    memstall_cost #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_cost (
        .cfg      (cfg_q),
        .acc_type (acc_type),
        .x_ext    (x_ext),
        .y_ext    (y_ext),
        .p_ext    (p_ext),
        .io_ext   (io_ext),
        .cost     (cost_w)
    );

    memstall_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .cost  (cost_w),
        .stall (stall),
        .done  (done)
    );
endmodule

// File: rtl/memstall_seq_chk.sv
module memstall_seq_chk #(
    parameter int FIELD_W = 4,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             stall,
    input logic             done,
    input logic [CNT_W-1:0] cost
);
    localparam int MAX_CST = 2 * ((1 << FIELD_W) - 1) + 2;

    logic             idle;
    logic [CNT_W-1:0] exp_q;
    logic [CNT_W:0]   run_q;

    assign idle = !stall && !done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            run_q <= '0;
        end else begin
            if (idle && req) exp_q <= cost;
            if (stall) run_q <= run_q + 1'b1;
            else       run_q <= '0;
        end
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> done);

    p_stall_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (run_q == {1'b0, exp_q}));

    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req && cost != '0) |=> stall);

    p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req && cost == '0) |=> (done && !stall));

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!stall && !done));

    p_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cost) <= MAX_CST);
endmodule

bind memstall_seq memstall_seq_chk #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .stall (stall),
    .done  (done),
    .cost  (cost_w)
);

// File: tb/memstall_seq_test.sv
module memstall_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic        req;
    logic [2:0]  acc_type;
    logic        x_ext, y_ext, p_ext, io_ext;
    logic        stall, done;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [15:0] cfg_m   = 16'hFFFF;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    memstall_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .acc_type(acc_type), .x_ext(x_ext), .y_ext(y_ext),
        .p_ext(p_ext), .io_ext(io_ext), .stall(stall), .done(done)
    );

    function automatic int exp_cost(logic [15:0] c, logic [2:0] t,
                                    logic xe, logic ye, logic pe, logic ie);
        int fx = int'(c[3:0]);
        int fy = int'(c[7:4]);
        int fp = int'(c[11:8]);
        int fi = int'(c[15:12]);
        case (t)
            3'd0: return xe ? fx : 0;
            3'd1: return ye ? fy : 0;
            3'd2: return pe ? fp : 0;
            3'd3: return ie ? fi : 0;
            3'd4: begin
                if (xe && ye) return 2 + fx + fy;
                if (xe) return fx;
                if (ye) return fy;
                return 0;
            end
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] t, logic xe, logic ye,
                                     logic pe, logic ie);
        case (t)
            3'd0: return xe ? "R3" : "R2";
            3'd1: return ye ? "R3" : "R2";
            3'd2: return pe ? "R3" : "R2";
            3'd3: return ie ? "R3" : "R2";
            3'd4: begin
                if (xe && ye) return "R6";
                if (xe) return "R5";
                if (ye) return "R4";
                return "R7";
            end
            default: return "R11";
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr_cfg(logic [15:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_m = v;
    endtask

    // wmode: 0 none, 1 write together with the request, 2 write during stall
    task automatic access(logic [2:0] t, logic xe, logic ye, logic pe, logic ie,
                          string tag, bit hold, int wmode, logic [15:0] wv);
        int  e = exp_cost(cfg_m, t, xe, ye, pe, ie);
        int  cnt = 0;
        bit  wrote = 1'b0;
        acc_type = t; x_ext = xe; y_ext = ye; p_ext = pe; io_ext = ie;
        req = 1'b1;
        if (wmode == 1) begin
            cfg_we = 1'b1; cfg_wdata = wv; wrote = 1'b1;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        if (hold) begin
            acc_type = 3'd4; x_ext = 1'b1; y_ext = 1'b1;
        end else begin
            req = 1'b0;
        end
        while (stall && cnt < 40) begin
            if (wmode == 2 && cnt == 0) begin
                cfg_we = 1'b1; cfg_wdata = wv; wrote = 1'b1;
            end
            cnt++;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        check(cnt == e, {tag, " stall length"}, cnt, e);
        check(done && !stall, {"R8 done after stall (", tag, ")"}, int'(done), 1);
        @(negedge clk);
        req = 1'b0;
        check(!done && !stall, hold ? "R9 idle after done with req held" :
              "R8 done lasts one cycle", int'({stall, done}), 0);
        if (wrote) cfg_m = wv;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req = 1'b0;
        acc_type = '0; x_ext = 0; y_ext = 0; p_ext = 0; io_ext = 0;
        repeat (3) @(negedge clk);
        check(!stall && !done, "R1 outputs low in reset", int'({stall, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!stall && !done, "R1 outputs low after reset", int'({stall, done}), 0);

        // R1: fields reset to 15
        access(3'd0, 1, 0, 0, 0, "R1", 0, 0, '0);
        access(3'd3, 0, 0, 0, 1, "R1", 0, 0, '0);
        access(3'd4, 1, 1, 0, 0, "R6 worst case", 0, 0, '0);

        wr_cfg(16'h4321);
        access(3'd0, 0, 1, 1, 1, "R2", 0, 0, '0);
        access(3'd1, 1, 0, 1, 1, "R2", 0, 0, '0);
        access(3'd2, 1, 1, 0, 1, "R2", 0, 0, '0);
        access(3'd3, 1, 1, 1, 0, "R2", 0, 0, '0);
        access(3'd0, 1, 0, 0, 0, "R3 X field", 0, 0, '0);
        access(3'd1, 0, 1, 0, 0, "R3 Y field", 0, 0, '0);
        access(3'd2, 0, 0, 1, 0, "R3 P field", 0, 0, '0);
        access(3'd3, 0, 0, 0, 1, "R3 IO field", 0, 0, '0);
        access(3'd4, 0, 1, 1, 1, "R4", 0, 0, '0);
        access(3'd4, 1, 0, 1, 1, "R5", 0, 0, '0);
        access(3'd4, 1, 1, 0, 0, "R6", 0, 0, '0);
        access(3'd4, 0, 0, 1, 1, "R7", 0, 0, '0);
        access(3'd5, 1, 1, 1, 1, "R11", 0, 0, '0);
        access(3'd6, 1, 1, 1, 1, "R11", 0, 0, '0);
        access(3'd7, 1, 1, 1, 1, "R11", 0, 0, '0);

        wr_cfg(16'h0000);
        access(3'd0, 1, 0, 0, 0, "R3 zero field", 0, 0, '0);
        access(3'd4, 1, 1, 0, 0, "R6 zero fields", 0, 0, '0);

        wr_cfg(16'h0005);
        access(3'd0, 1, 0, 0, 0, "R9 held request", 1, 0, '0);
        access(3'd0, 1, 0, 0, 0, "R10 write during stall", 0, 2, 16'h0009);
        access(3'd0, 1, 0, 0, 0, "R10 new value used", 0, 0, '0);
        access(3'd0, 1, 0, 0, 0, "R10 write with request", 0, 1, 16'h0002);
        access(3'd0, 1, 0, 0, 0, "R10 new value used", 0, 0, '0);

        for (int i = 0; i < 200; i++) begin
            logic [2:0] t  = 3'($urandom_range(0, 7));
            logic       xe = 1'($urandom);
            logic       ye = 1'($urandom);
            logic       pe = 1'($urandom);
            logic       ie = 1'($urandom);
            if ($urandom_range(0, 3) == 0) wr_cfg(16'($urandom));
            access(t, xe, ye, pe, ie, tag_of(t, xe, ye, pe, ie),
                   1'($urandom_range(0, 4) == 0), 0, '0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule